// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Bank

A bank of independent pulse-width channels programmed through a small word-addressed register window. Each channel owns a period word, a duty word and a control word. The control word picks a power-of-two divider for a shared timing tick and can invert the output. Every channel has its own divider and counter and drives one output pin.

Software writes control and duty first. These land only in shadow copies. Writing the period word arms a commit, and the whole set moves into the active copy at the next period boundary. An update therefore never produces a partly old, partly new cycle on the pin. A period of zero is committed the same way. It lets the running cycle finish and then holds the pin low.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, every channel is stopped and every register reads as zero.
- R2: Word addresses 0x400+4*ch, 0x420+4*ch and 0x440+4*ch select the period, duty and control word of channel ch. Reads return the last value written to that word, with control bits [1:0] and bit 5 kept and other control bits reading zero. An address outside these windows reads zero.
- R3: While a channel runs with counter value n in 0..period-1, its non-inverted output is high when n < duty and low otherwise. The counter starts at 0 on the cycle a commit takes effect.
- R4: Control bits [1:0] hold a value s. The counter advances once per 2^s tick_i pulses, so one period lasts period*2^s ticks.
- R5: Control bit 5 set inverts a running channel's output.
- R6: Duty and control writes without a following period write do not change the output.
- R7: A period write on a running channel takes effect at the end of the current period and not before. From that boundary, the latest shadow values for period, duty and control apply.
- R8: A committed period of zero stops the channel at the end of its running period. After that the output stays low whatever the polarity bit holds.
- R9: A duty of 0 keeps a running output inactive. A duty at or above the period keeps it active.
- R10: A commit on a stopped channel takes effect at the first clock edge with tick_i high. Without tick_i no counter, divider or output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable, one pulse per count unit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register word |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| pwm_o | output | N_CH | Channel outputs |

## Verification
The bench keeps the default eight channels, 16-bit counters and a 2-bit divider select, so every register window is decoded at full size. It holds tick_i high on most cycles, so even the divide-by-4 setting covers whole periods within a few dozen clocks. Commits in the middle of a period and shutdowns can then be checked cycle by cycle. It also holds tick_i low for a stretch. This shows that a commit on a stopped channel waits for the tick and that a running waveform freezes during the gap.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DIV_W        = 2;
  localparam int CTRL_POL_BIT = 5;
  localparam int PER_BASE     = 'h400;
  localparam int DUTY_BASE    = 'h420;
  localparam int CTRL_BASE    = 'h440;

  typedef enum logic [1:0] {
    K_NONE,
    K_PER,
    K_DUTY,
    K_CTRL
  } reg_kind_e;

  typedef struct packed {
    logic             pol;
    logic [DIV_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/pwm_reg_dec.sv
module pwm_reg_dec
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 12,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CH_W-1:0]   ch_o
);
  localparam int SPAN = 4 * N_CH;

  int a;
  int off;

  always_comb begin
    a      = int'(addr_i);
    kind_o = K_NONE;
    off    = 0;
    if (a[1:0] == 2'b00) begin
      if (a >= PER_BASE && a < PER_BASE + SPAN) begin
        kind_o = K_PER;
        off    = a - PER_BASE;
      end else if (a >= DUTY_BASE && a < DUTY_BASE + SPAN) begin
        kind_o = K_DUTY;
        off    = a - DUTY_BASE;
      end else if (a >= CTRL_BASE && a < CTRL_BASE + SPAN) begin
        kind_o = K_CTRL;
        off    = a - CTRL_BASE;
      end
    end
    ch_o = off[CH_W+1:2];
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] sel_i,
  input  logic             clr_i,
  input  logic             bypass_i,
  output logic             step_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             wrap;

  assign lim    = PRE_W'((1 << sel_i) - 1);
  assign wrap   = (pre_q == lim);
  assign step_o = tick_i && (bypass_i || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_i)  pre_q <= wrap ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_per_i,
  input  logic             wr_duty_i,
  input  logic             wr_ctrl_i,
  input  logic [CNT_W-1:0] wval_i,
  input  ctrl_t            wctrl_i,
  output logic [CNT_W-1:0] sh_per_o,
  output logic [CNT_W-1:0] sh_duty_o,
  output ctrl_t            sh_ctrl_o,
  output logic             run_o,
  output logic             commit_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] sh_per_q, sh_duty_q;
  ctrl_t            sh_ctrl_q;
  logic             pend_q;
  logic [CNT_W-1:0] act_per_q, act_duty_q;
  ctrl_t            act_ctrl_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step, last, bnd, commit;

  pwm_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .sel_i   (act_ctrl_q.sel),
    .clr_i   (commit),
    .bypass_i(!run_q),
    .step_o  (step)
  );

  assign last   = run_q && (cnt_q == act_per_q - 1'b1);
  assign bnd    = step && (!run_q || last);
  assign commit = bnd && pend_q;

  // shadow side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_per_q  <= '0;
      sh_duty_q <= '0;
      sh_ctrl_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_per_i)  sh_per_q  <= wval_i;
      if (wr_duty_i) sh_duty_q <= wval_i;
      if (wr_ctrl_i) sh_ctrl_q <= wctrl_i;
      // a period write in the commit cycle stays armed for the next boundary
      if (wr_per_i)    pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
    end
  end

  // active side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per_q  <= '0;
      act_duty_q <= '0;
      act_ctrl_q <= '0;
      run_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (commit) begin
      act_per_q  <= sh_per_q;
      act_duty_q <= sh_duty_q;
      act_ctrl_q <= sh_ctrl_q;
      run_q      <= (sh_per_q != '0);
      cnt_q      <= '0;
    end else if (step && run_q) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign pwm_o     = run_q && ((cnt_q < act_duty_q) ^ act_ctrl_q.pol);
  assign sh_per_o  = sh_per_q;
  assign sh_duty_o = sh_duty_q;
  assign sh_ctrl_o = sh_ctrl_q;
  assign run_o     = run_q;
  assign commit_o  = commit;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  reg_kind_e        kind;
  logic [CH_W-1:0]  ch;
  ctrl_t            wctrl;
  logic [CNT_W-1:0] sh_per  [N_CH];
  logic [CNT_W-1:0] sh_duty [N_CH];
  ctrl_t            sh_ctrl [N_CH];
  logic [N_CH-1:0]  run_vec;
  logic [N_CH-1:0]  commit_vec;
  logic             wdata_unused;

  assign wctrl.pol    = reg_wdata_i[CTRL_POL_BIT];
  assign wctrl.sel    = reg_wdata_i[DIV_W-1:0];
  assign wdata_unused = ^reg_wdata_i;

  pwm_reg_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(reg_addr_i),
    .kind_o(kind),
    .ch_o  (ch)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = reg_we_i && (ch == CH_W'(c));

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .wr_per_i (sel_c && kind == K_PER),
      .wr_duty_i(sel_c && kind == K_DUTY),
      .wr_ctrl_i(sel_c && kind == K_CTRL),
      .wval_i   (reg_wdata_i[CNT_W-1:0]),
      .wctrl_i  (wctrl),
      .sh_per_o (sh_per[c]),
      .sh_duty_o(sh_duty[c]),
      .sh_ctrl_o(sh_ctrl[c]),
      .run_o    (run_vec[c]),
      .commit_o (commit_vec[c]),
      .pwm_o    (pwm_o[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (kind)
      K_PER:  reg_rdata_o[CNT_W-1:0] = sh_per[ch];
      K_DUTY: reg_rdata_o[CNT_W-1:0] = sh_duty[ch];
      K_CTRL: begin
        reg_rdata_o[DIV_W-1:0]    = sh_ctrl[ch].sel;
        reg_rdata_o[CTRL_POL_BIT] = sh_ctrl[ch].pol;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic [N_CH-1:0] pwm_o,
  input logic [N_CH-1:0] run_vec,
  input logic [N_CH-1:0] commit_vec
);
  // R10
  frozen_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pwm_o));

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    // R8
    stopped_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_vec[c] |-> !pwm_o[c]);
    // R8
    stop_at_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_vec[c]) |-> $past(commit_vec[c]));
    // R7
    start_at_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_vec[c]) |-> $past(commit_vec[c]));
    // R10
    commit_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_vec[c] |-> tick_i);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .pwm_o     (pwm_o),
  .run_vec   (run_vec),
  .commit_vec(commit_vec)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int N_CH = 8;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        tick_i = 1;
  logic        reg_we_i = 0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [N_CH-1:0] pwm_o;

  always #2 clk_i = ~clk_i;

  pwm_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .pwm_o(pwm_o)
  );

  typedef struct {int per; int duty; int s; bit pol; bit run;} cfg_t;
  typedef struct {int ch; bit exp; string tag; int cyc;} item_t;

  item_t q[$];
  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic cfg_t mk(int per, int duty, int s, bit pol);
    cfg_t c;
    c.per = per; c.duty = duty; c.s = s; c.pol = pol; c.run = (per != 0);
    return c;
  endfunction

  function automatic bit exp_at(cfg_t c, int t0, int now);
    int k;
    if (!c.run) return 1'b0;
    k = now - t0;
    return (((k >> c.s) % c.per) < c.duty) ^ c.pol;
  endfunction

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (pwm_o[it.ch] !== it.exp) begin
        n_fail++;
        $display("FAIL %s ch%0d cyc %0d: got %0b exp %0b", it.tag, it.ch, it.cyc,
                 pwm_o[it.ch], it.exp);
      end
    end
  end

  task automatic wr(int addr, int data, output int e);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 12'(addr); reg_wdata_i = data;
    @(posedge clk_i); #1;
    reg_we_i = 0;
    e = cyc;
  endtask

  task automatic rd_chk(int addr, int exp, string tag);
    @(negedge clk_i);
    reg_addr_i = 12'(addr);
    #1;
    n_tests++;
    if (reg_rdata_o !== 32'(exp)) begin
      n_fail++;
      $display("FAIL %s rd %h: got %h exp %h", tag, addr, reg_rdata_o, exp);
    end
  endtask

  // driver: pushes expected bits, switching from cfg a to cfg b at edge tb
  task automatic watch(int ch, cfg_t a, int ta, cfg_t b, int tb, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(posedge clk_i); #1;
      it.ch = ch; it.tag = tag; it.cyc = cyc;
      it.exp = (cyc < tb) ? exp_at(a, ta, cyc) : exp_at(b, tb, cyc);
      q.push_back(it);
    end
  endtask

  task automatic cfg_ch(int ch, int ctrl, int duty, int per, output int e);
    int d;
    wr('h440 + 4*ch, ctrl, d);
    wr('h420 + 4*ch, duty, d);
    wr('h400 + 4*ch, per, e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_t off, c0, c0n, c1, c1n, c2, c4, c5, c6;
    int e, t0, t1, t2, t4, t5, t6, sw, v, d;
    off = mk(0, 0, 0, 0);

    repeat (3) @(negedge clk_i);
    // R1: outputs and registers clear in reset
    n_tests++;
    if (pwm_o !== '0) begin n_fail++; $display("FAIL R1 pwm got %b exp 0", pwm_o); end
    rst_ni = 1;
    rd_chk('h400, 0, "R1");
    rd_chk('h424, 0, "R1");
    rd_chk('h45C, 0, "R1");
    watch(0, off, 0, off, 0, 3, "R1");

    // R2: decode and readback of shadow words
    cfg_ch(3, 'hFF, 'h1234, 'hABCD, e);
    rd_chk('h44C, 'h23, "R2");
    rd_chk('h42C, 'h1234, "R2");
    rd_chk('h40C, 'hABCD, "R2");
    rd_chk('h408, 0, "R2");
    rd_chk('h460, 0, "R2");
    rd_chk('h402, 0, "R2");
    wr('h40C, 0, d);

    // R3: basic compare, divide by 1
    c0 = mk(8, 3, 0, 0);
    cfg_ch(0, 'h0, 3, 8, e); t0 = e + 1;
    watch(0, off, 0, c0, t0, 20, "R3");

    // R4: divide by 4
    c1 = mk(3, 2, 2, 0);
    cfg_ch(1, 'h2, 2, 3, e); t1 = e + 1;
    watch(1, off, 0, c1, t1, 30, "R4");

    // R5: inverted polarity, divide by 2
    c2 = mk(4, 1, 1, 1);
    cfg_ch(2, 'h21, 1, 4, e); t2 = e + 1;
    watch(2, off, 0, c2, t2, 20, "R5");

    // R9: duty 0 and duty above period
    c4 = mk(5, 0, 0, 0);
    cfg_ch(4, 0, 0, 5, e); t4 = e + 1;
    watch(4, off, 0, c4, t4, 12, "R9");
    c5 = mk(5, 9, 0, 0);
    cfg_ch(5, 0, 9, 5, e); t5 = e + 1;
    watch(5, off, 0, c5, t5, 12, "R9");

    // R6: shadow-only writes leave ch0 unchanged
    wr('h420, 7, d);
    wr('h440, 'h20, d);
    watch(0, c0, t0, c0, t0, 30, "R6");

    // R7: commit waits for the period boundary
    c0n = mk(8, 7, 0, 1);
    wr('h400, 8, e);
    sw = t0 + ((e - t0) / 8 + 1) * 8;
    watch(0, c0, t0, c0n, sw, 30, "R7");

    // R8: zero period stops after the running period, low despite polarity
    wr('h444, 'h22, d);
    wr('h404, 0, e);
    sw = t1 + ((e - t1) / 12 + 1) * 12;
    c1n = off;
    watch(1, c1, t1, c1n, sw, 40, "R8");

    // R10: commit on a stopped channel waits for tick_i
    @(negedge clk_i); tick_i = 0;
    c6 = mk(4, 2, 0, 0);
    cfg_ch(6, 0, 2, 4, e);
    watch(6, off, 0, off, 0, 6, "R10");
    @(negedge clk_i); tick_i = 1; t6 = cyc + 1;
    watch(6, off, 0, c6, t6, 10, "R10");
    v = exp_at(c6, t6, cyc);
    @(negedge clk_i); tick_i = 0;
    for (int i = 0; i < 6; i++) begin
      item_t it;
      @(posedge clk_i); #1;
      it.ch = 6; it.exp = v[0]; it.tag = "R10"; it.cyc = cyc;
      q.push_back(it);
    end
    @(negedge clk_i); tick_i = 1;

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule